// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit forms the address that a load, store or branch uses, from fields the decoder pulls out of an instruction and from register values read for it. A mode code picks how the pieces are combined: a literal address, a register alone, a register plus a signed displacement, two registers summed, two registers plus a displacement, a base plus an index shifted by the element size, the next-instruction address plus a signed displacement, and the two stepping modes that move a pointer through memory by one item after or before the access.

A request is taken on a clock edge when `req_valid` is high, and every output is registered, so results appear one cycle later with `out_valid`. The stepping modes also produce a new base value and a write enable for the register file. A fault input raised with the request cancels that write-back so the instruction can be restarted with its registers as they were. In scaled mode an optional bounds check compares the raw index against a lower and an upper limit and raises a violation flag. All sums wrap modulo 2^AW.

Top module: `eff_addr_gen`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid`, `ea`, `wb_en`, `wb_val` and `bound_err` are all zero; every accepted request shows its results exactly one cycle after the edge on which `req_valid` was high, with `out_valid` high for that one cycle.
- R2: Mode code 0 (absolute) gives `ea` equal to `abs_addr`.
- R3: Mode code 2 (base plus displacement) gives `ea` = base + sign-extended `offset` modulo 2^AW; when `base_sel` is 0 the base reads as zero, so the result is the sign-extended offset alone.
- R4: Mode code 3 gives base + `index_val`; mode code 4 gives base + `index_val` + sign-extended `offset`, both modulo 2^AW.
- R5: Mode code 5 (scaled) gives base + (`index_val` shifted left by `item_size`), where `item_size` codes 0,1,2,3 mean 1,2,4,8 bytes.
- R6: Mode code 6 (PC-relative) gives `next_pc` + sign-extended `offset`, so a negative offset points backwards.
- R7: Mode code 7 (post-increment) gives `ea` equal to the unmodified base, `wb_val` = base + item bytes, and `wb_en` high.
- R8: Mode code 8 (pre-decrement) gives `ea` and `wb_val` both equal to base − item bytes, with `wb_en` high.
- R9: A request with `fault` high leaves `wb_en` low while `ea` and `wb_val` are computed as without the fault.
- R10: In mode 5 with `bound_en` high, `bound_err` is high when `index_val` (unsigned) is below `lo_bound` or above `hi_bound`, and low when it lies between them inclusive; in every other mode, or with `bound_en` low, it stays low.
- R11: In modes other than 7 and 8 `wb_en` is low; mode codes 9 to 15 are reserved and give `ea` of zero.
- R12: Mode code 1 (register indirect) gives `ea` equal to the base register value, or zero when `base_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Address mode code |
| item_size | input | 2 | Log2 of item bytes; step and scale |
| base_sel | input | RW | Base register number (0 reads as zero) |
| base_val | input | AW | Base register contents |
| index_val | input | AW | Index register contents |
| next_pc | input | AW | Address of the next instruction |
| offset | input | OW | Signed displacement |
| abs_addr | input | AW | Literal address field |
| lo_bound | input | AW | Lowest allowed index |
| hi_bound | input | AW | Highest allowed index |
| bound_en | input | 1 | Enable index bounds check |
| fault | input | 1 | Cancel base write-back |
| out_valid | output | 1 | Results valid |
| ea | output | AW | Effective address |
| wb_en | output | 1 | Base write-back enable |
| wb_val | output | AW | New base value |
| bound_err | output | 1 | Index outside bounds |

## Verification
The write-back of a stepping mode and the fault that cancels it can land on the same request, and that is the collision that matters most for restart. The bench issues post-increment and pre-decrement requests with `fault` raised alongside them and judges that the address and the would-be base value still come out correct while the enable stays low, then repeats the request without the fault to show the enable returns. A second overlap, a bounds violation arriving on a scaled request that also uses register 0 as base, is checked for both the flag and the address.

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    mode,
  input  logic [1:0]    item_size,
  input  logic [RW-1:0] base_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] next_pc,
  input  logic [OW-1:0] offset,
  input  logic [AW-1:0] abs_addr,
  input  logic [AW-1:0] lo_bound,
  input  logic [AW-1:0] hi_bound,
  input  logic          bound_en,
  input  logic          fault,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          bound_err
);
  localparam logic [3:0] M_ABS    = 4'd0;
  localparam logic [3:0] M_RIND   = 4'd1;
  localparam logic [3:0] M_BOFF   = 4'd2;
  localparam logic [3:0] M_BIDX   = 4'd3;
  localparam logic [3:0] M_BIDXO  = 4'd4;
  localparam logic [3:0] M_SCALE  = 4'd5;
  localparam logic [3:0] M_PCREL  = 4'd6;
  localparam logic [3:0] M_POSTI  = 4'd7;
  localparam logic [3:0] M_PRED   = 4'd8;

  logic [AW-1:0] base_eff, off_ext, step, scaled_idx;
  logic [AW-1:0] ea_nxt, wb_nxt;
  logic          auto_mode, out_of_range;

  assign base_eff   = (base_sel == '0) ? '0 : base_val;
  assign off_ext    = {{(AW-OW){offset[OW-1]}}, offset};
  assign step       = AW'(1) << item_size;
  assign scaled_idx = index_val << item_size;
  assign auto_mode  = (mode == M_POSTI) || (mode == M_PRED);
  assign out_of_range = (index_val < lo_bound) || (index_val > hi_bound);

  always_comb begin
    ea_nxt = '0;
    wb_nxt = base_eff;
    unique case (mode)
      M_ABS:   ea_nxt = abs_addr;
      M_RIND:  ea_nxt = base_eff;
      M_BOFF:  ea_nxt = base_eff + off_ext;
      M_BIDX:  ea_nxt = base_eff + index_val;
      M_BIDXO: ea_nxt = base_eff + index_val + off_ext;
      M_SCALE: ea_nxt = base_eff + scaled_idx;
      M_PCREL: ea_nxt = next_pc + off_ext;
      M_POSTI: begin
        ea_nxt = base_eff;
        wb_nxt = base_eff + step;
      end
      M_PRED: begin
        ea_nxt = base_eff - step;
        wb_nxt = base_eff - step;
      end
      default: ea_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
      bound_err <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        ea     <= ea_nxt;
        wb_val <= wb_nxt;
      end
      wb_en     <= req_valid && auto_mode && !fault;
      bound_err <= req_valid && (mode == M_SCALE) && bound_en && out_of_range;
    end
  end
endmodule

module eff_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [3:0]    mode,
  input logic [1:0]    item_size,
  input logic          fault,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic          wb_en,
  input logic [AW-1:0] wb_val,
  input logic          bound_err
);
  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R11
  wb_only_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid && ($past(mode) == 4'd7 || $past(mode) == 4'd8));
  // R9
  fault_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault) |=> !wb_en);
  // R7
  post_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 4'd7) |=> wb_val == ea + (AW'(1) << $past(item_size)));
  // R8
  pre_dec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 4'd8) |=> wb_val == ea);
  // R10
  bound_only_scaled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bound_err |-> out_valid && $past(mode) == 4'd5);
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
  .item_size(item_size), .fault(fault), .out_valid(out_valid), .ea(ea),
  .wb_en(wb_en), .wb_val(wb_val), .bound_err(bound_err)
);

// File: tb/test_eff_addr_gen.sv
module test_eff_addr_gen;
  localparam int AW = 32;
  localparam int OW = 16;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [3:0]    mode = '0;
  logic [1:0]    item_size = '0;
  logic [RW-1:0] base_sel = '0;
  logic [AW-1:0] base_val = '0, index_val = '0, next_pc = '0, abs_addr = '0;
  logic [AW-1:0] lo_bound = '0, hi_bound = '0;
  logic [OW-1:0] offset = '0;
  logic          bound_en = 1'b0, fault = 1'b0;
  logic          out_valid, wb_en, bound_err;
  logic [AW-1:0] ea, wb_val;

  int checks = 0;
  int fails = 0;

  always #5ns clk = ~clk;

  eff_addr_gen #(.AW(AW), .OW(OW), .RW(RW)) i_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .item_size(item_size), .base_sel(base_sel), .base_val(base_val),
    .index_val(index_val), .next_pc(next_pc), .offset(offset),
    .abs_addr(abs_addr), .lo_bound(lo_bound), .hi_bound(hi_bound),
    .bound_en(bound_en), .fault(fault), .out_valid(out_valid), .ea(ea),
    .wb_en(wb_en), .wb_val(wb_val), .bound_err(bound_err)
  );

  function automatic logic [AW-1:0] sx(input logic [OW-1:0] v);
    return {{(AW-OW){v[OW-1]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input logic [1:0] sz, input logic [RW-1:0] bs,
                       input logic [AW-1:0] b, input logic [AW-1:0] ix, input logic [OW-1:0] off);
    @(negedge clk);
    req_valid = 1'b1; mode = m; item_size = sz; base_sel = bs;
    base_val = b; index_val = ix; offset = off;
    @(negedge clk);
    req_valid = 1'b0; fault = 1'b0; bound_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", AW'(out_valid), '0);
    chk("R1 ea", ea, '0);
    chk("R1 wb_en", AW'(wb_en), '0);
    chk("R1 wb_val", wb_val, '0);
    chk("R1 bound_err", AW'(bound_err), '0);
  endtask

  task automatic t_absolute;
    abs_addr = 32'hCAFE_0010;
    issue(4'd0, 2'd0, 5'd3, 32'h1111, 32'h2, 16'h4);
    chk("R1 valid after req", AW'(out_valid), 1);
    chk("R2 absolute", ea, 32'hCAFE_0010);
    chk("R11 no wb", AW'(wb_en), 0);
    @(negedge clk);
    chk("R1 valid one cycle", AW'(out_valid), 0);
  endtask

  task automatic t_reg_ind;
    issue(4'd1, 2'd0, 5'd4, 32'h0000_8000, 32'h0, 16'h0);
    chk("R12 reg indirect", ea, 32'h0000_8000);
    issue(4'd1, 2'd0, 5'd0, 32'h0000_8000, 32'h0, 16'h0);
    chk("R12 reg0 zero", ea, 32'h0);
  endtask

  task automatic t_base_off;
    issue(4'd2, 2'd0, 5'd2, 32'h0000_1000, 32'h0, 16'hFFF0);
    chk("R3 negative disp", ea, 32'h0000_1000 + sx(16'hFFF0));
    issue(4'd2, 2'd0, 5'd0, 32'h0000_1000, 32'h0, 16'h7FFC);
    chk("R3 reg0 absolute", ea, 32'h0000_7FFC);
    issue(4'd2, 2'd0, 5'd1, 32'hFFFF_FFF0, 32'h0, 16'h0020);
    chk("R3 wrap", ea, 32'h0000_0010);
  endtask

  task automatic t_base_idx;
    issue(4'd3, 2'd2, 5'd6, 32'h0000_2000, 32'h0000_0044, 16'h0);
    chk("R4 base+index", ea, 32'h0000_2044);
    issue(4'd4, 2'd2, 5'd6, 32'h0000_2000, 32'h0000_0044, 16'hFFFC);
    chk("R4 base+index+disp", ea, 32'h0000_2040);
  endtask

  task automatic t_scaled;
    for (int s = 0; s < 4; s++) begin
      issue(4'd5, 2'(s), 5'd7, 32'h0001_0000, 32'h0000_0003, 16'h0);
      chk($sformatf("R5 scaled size %0d", s), ea, 32'h0001_0000 + (32'h3 << s));
    end
  endtask

  task automatic t_pcrel;
    next_pc = 32'h0040_0100;
    issue(4'd6, 2'd0, 5'd9, 32'hDEAD, 32'h0, 16'hFF00);
    chk("R6 backward", ea, 32'h0040_0000);
    issue(4'd6, 2'd0, 5'd9, 32'hDEAD, 32'h0, 16'h0080);
    chk("R6 forward", ea, 32'h0040_0180);
  endtask

  task automatic t_auto;
    issue(4'd7, 2'd2, 5'd8, 32'h0000_3000, 32'h0, 16'h0);
    chk("R7 ea", ea, 32'h0000_3000);
    chk("R7 wb_val", wb_val, 32'h0000_3004);
    chk("R7 wb_en", AW'(wb_en), 1);
    issue(4'd8, 2'd3, 5'd8, 32'h0000_3000, 32'h0, 16'h0);
    chk("R8 ea", ea, 32'h0000_2FF8);
    chk("R8 wb_val", wb_val, 32'h0000_2FF8);
    chk("R8 wb_en", AW'(wb_en), 1);
  endtask

  task automatic t_fault;
    fault = 1'b1;
    issue(4'd7, 2'd1, 5'd8, 32'h0000_5000, 32'h0, 16'h0);
    chk("R9 inc wb_en", AW'(wb_en), 0);
    chk("R9 inc ea", ea, 32'h0000_5000);
    chk("R9 inc wb_val", wb_val, 32'h0000_5002);
    fault = 1'b1;
    issue(4'd8, 2'd0, 5'd8, 32'h0000_5000, 32'h0, 16'h0);
    chk("R9 dec wb_en", AW'(wb_en), 0);
    chk("R9 dec ea", ea, 32'h0000_4FFF);
    issue(4'd8, 2'd0, 5'd8, 32'h0000_5000, 32'h0, 16'h0);
    chk("R9 retry wb_en", AW'(wb_en), 1);
  endtask

  task automatic t_bounds;
    lo_bound = 32'd4; hi_bound = 32'd10;
    bound_en = 1'b1;
    issue(4'd5, 2'd2, 5'd0, 32'h0, 32'd3, 16'h0);
    chk("R10 below", AW'(bound_err), 1);
    chk("R10 below ea", ea, 32'd12);
    bound_en = 1'b1;
    issue(4'd5, 2'd2, 5'd1, 32'h100, 32'd11, 16'h0);
    chk("R10 above", AW'(bound_err), 1);
    bound_en = 1'b1;
    issue(4'd5, 2'd2, 5'd1, 32'h100, 32'd4, 16'h0);
    chk("R10 at low edge", AW'(bound_err), 0);
    bound_en = 1'b1;
    issue(4'd5, 2'd2, 5'd1, 32'h100, 32'd10, 16'h0);
    chk("R10 at high edge", AW'(bound_err), 0);
    bound_en = 1'b0;
    issue(4'd5, 2'd2, 5'd1, 32'h100, 32'd20, 16'h0);
    chk("R10 disabled", AW'(bound_err), 0);
    bound_en = 1'b1;
    issue(4'd3, 2'd2, 5'd1, 32'h100, 32'd20, 16'h0);
    chk("R10 other mode", AW'(bound_err), 0);
  endtask

  task automatic t_reserved;
    issue(4'd12, 2'd1, 5'd1, 32'h100, 32'h8, 16'h4);
    chk("R11 reserved ea", ea, '0);
    chk("R11 reserved wb", AW'(wb_en), 0);
  endtask

  initial begin
    #20000ns;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_absolute;
    t_reg_ind;
    t_base_off;
    t_base_idx;
    t_scaled;
    t_pcrel;
    t_auto;
    t_fault;
    t_bounds;
    t_reserved;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule